// File: doc/BRIEF.md
# Memory-Backed Byte-Wide Long Pseudo-Random Generator

This block emits one pseudo-random byte per enabled clock. Internally it runs eight long linear feedback shift registers in parallel, one per output bit. Their history is not kept in a flip-flop chain. It sits in a word-organised store that is treated as a ring, and a wrapping pointer moves the logical head of the register instead of moving data. On each enabled clock the block reads two old words at fixed distances behind the pointer. It combines them bitwise with XNOR, writes the result over the oldest word and drives the result out. A typical use is reproducible error or traffic injection, where the same sequence must come back after every reset.

The register length is a parameter. The long form has 100 stages with feedback from stages 100 and 63. A shorter form has 63 stages with feedback from stages 63 and 62. A custom length with its own short tap can also be chosen.

Reset is asserted asynchronously and active low. The block synchronises its release internally with two flops. After reset every stored word is zero, which is a legal start for XNOR feedback. The all-ones word is the state that must never be loaded.

Top module: `prng_bytestream`

## Requirements
- R1: While reset is asserted, `rnd_o` is 0x00 and `rnd_vld_o` is 0. Reset clears every stored word to zero and sets the pointer to zero.
- R2: In the default long form, each output byte equals, lane by lane, the XNOR of the byte produced 100 enabled steps earlier and the byte produced 63 enabled steps earlier. A byte from before the first step counts as 0x00.
- R3: Each of the eight bit lanes is its own register. Bit k of the output depends only on earlier values of bit k.
- R4: The new byte overwrites the oldest stored byte. The write pointer counts from 0 up to DEPTH-1 and then wraps to 0, so the sequence keeps matching a plain shift register past every wrap.
- R5: When `en_i` is low at a clock edge, the output, the pointer and the store keep their values. The next enabled step continues the sequence as if the idle cycle had not happened.
- R6: `rnd_vld_o` is 1 in the cycle after a clock edge at which the block was out of reset and `en_i` was high. Otherwise it is 0.
- R7: With `LEN_SEL = LEN_63`, the register has 63 stages and uses feedback from the bytes 63 and 62 steps back.
- R8: With `LEN_SEL = LEN_CUSTOM`, depth and short tap come from `CUSTOM_DEPTH` and `CUSTOM_TAP`. With 7 stages and tap 6, each lane has a period of exactly 127 steps, and the all-zero state first comes back after step 127.
- R9: The first enabled step after reset outputs 0xFF.
- R10: Reset assertion clears the outputs at once, without waiting for a clock. After release, the first two clock edges make no update, and the third edge is the first one that can step the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised internally |
| en_i | input | 1 | Step enable |
| rnd_o | output | WIDTH | Latest pseudo-random byte |
| rnd_vld_o | output | 1 | High when the last edge produced a new byte |

## Verification
Every result is due in the cycle after the clock edge that produces it. The output register is the only stage between the feedback and the pins, so the bench samples one time unit after each edge and compares the byte against a model that shifts a plain byte vector. Reset release is handled by counting edges, so the model steps only from the third edge onward. Assertion of reset is checked one time unit after reset falls, with no clock edge in between. The 127-step period of the reduced register is judged from a recorded trace once the run is over.

// File: rtl/prng_pkg.sv
package prng_pkg;

  typedef enum logic [1:0] {
    LEN_100    = 2'd0,
    LEN_63     = 2'd1,
    LEN_CUSTOM = 2'd2
  } len_sel_e;

  // number of stages for the chosen form
  function automatic int unsigned depth_of(len_sel_e sel, int unsigned cust_depth);
    case (sel)
      LEN_100: return 100;
      LEN_63:  return 63;
      default: return cust_depth;
    endcase
  endfunction

  // distance of the short feedback tap behind the write pointer
  function automatic int unsigned tap_of(len_sel_e sel, int unsigned cust_tap);
    case (sel)
      LEN_100: return 63;
      LEN_63:  return 62;
      default: return cust_tap;
    endcase
  endfunction

endpackage

// File: rtl/prng_rst_sync.sv
module prng_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/prng_addr_ctr.sv
module prng_addr_ctr #(
  parameter int unsigned DEPTH = 100,
  parameter int unsigned TAPD  = 63,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] tap_addr_o
);

  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
  localparam logic [AW-1:0] TAP_OFS = AW'(TAPD);
  localparam logic [AW-1:0] TAP_WRP = AW'(DEPTH - TAPD);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (en_i) begin
      if (ptr_q == LAST) ptr_d = '0;
      else               ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  // short tap: pointer minus tap distance, modulo depth
  always_comb begin
    if (ptr_q >= TAP_OFS) tap_addr_o = ptr_q - TAP_OFS;
    else                  tap_addr_o = ptr_q + TAP_WRP;
  end

  assign wr_ptr_o = ptr_q;

endmodule

// File: rtl/prng_hist_mem.sv
module prng_hist_mem #(
  parameter int unsigned DEPTH = 100,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_a_i,
  input  logic [AW-1:0]    raddr_b_i,
  output logic [WIDTH-1:0] rdata_a_o,
  output logic [WIDTH-1:0] rdata_b_o
);

  logic [WIDTH-1:0] word_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic             hit;
    logic [WIDTH-1:0] word_d;

    always_comb begin
      hit    = we_i && (waddr_i == AW'(w));
      word_d = hit ? wdata_i : word_q[w];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[w] <= '0;
      else         word_q[w] <= word_d;
    end
  end

  assign rdata_a_o = word_q[raddr_a_i];
  assign rdata_b_o = word_q[raddr_b_i];

endmodule

// File: rtl/prng_feedback.sv
module prng_feedback #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] long_tap_i,
  input  logic [WIDTH-1:0] short_tap_i,
  output logic [WIDTH-1:0] fb_o
);

  for (genvar l = 0; l < WIDTH; l++) begin : g_lane
    assign fb_o[l] = ~(long_tap_i[l] ^ short_tap_i[l]);
  end

endmodule

// File: rtl/prng_bytestream.sv
module prng_bytestream #(
  parameter prng_pkg::len_sel_e LEN_SEL = prng_pkg::LEN_100,
  parameter int unsigned CUSTOM_DEPTH   = 7,
  parameter int unsigned CUSTOM_TAP     = 6,
  parameter int unsigned WIDTH          = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [WIDTH-1:0] rnd_o,
  output logic             rnd_vld_o
);

  localparam int unsigned DEPTH = prng_pkg::depth_of(LEN_SEL, CUSTOM_DEPTH);
  localparam int unsigned TAPD  = prng_pkg::tap_of(LEN_SEL, CUSTOM_TAP);
  localparam int unsigned AW    = $clog2(DEPTH);

  logic             rst_core_n;
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    tap_addr;
  logic [WIDTH-1:0] oldest_word;
  logic [WIDTH-1:0] tap_word;
  logic [WIDTH-1:0] fb_word;
  logic [WIDTH-1:0] rnd_q;
  logic [WIDTH-1:0] rnd_d;
  logic             vld_q;
  logic             vld_d;

  prng_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_core_n)
  );

  prng_addr_ctr #(.DEPTH(DEPTH), .TAPD(TAPD)) u_addr_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_core_n),
    .en_i       (en_i),
    .wr_ptr_o   (wr_ptr),
    .tap_addr_o (tap_addr)
  );

  prng_hist_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_hist_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_core_n),
    .we_i      (en_i),
    .waddr_i   (wr_ptr),
    .wdata_i   (fb_word),
    .raddr_a_i (wr_ptr),
    .raddr_b_i (tap_addr),
    .rdata_a_o (oldest_word),
    .rdata_b_o (tap_word)
  );

  prng_feedback #(.WIDTH(WIDTH)) u_feedback (
    .long_tap_i  (oldest_word),
    .short_tap_i (tap_word),
    .fb_o        (fb_word)
  );

  always_comb begin
    rnd_d = en_i ? fb_word : rnd_q;
    vld_d = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rnd_q <= '0;
      vld_q <= 1'b0;
    end else begin
      rnd_q <= rnd_d;
      vld_q <= vld_d;
    end
  end

  assign rnd_o     = rnd_q;
  assign rnd_vld_o = vld_q;

endmodule

// File: rtl/prng_bytestream_chk.sv
module prng_bytestream_chk #(
  parameter int unsigned DEPTH = 100,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             en_i,
  input logic [AW-1:0]    wr_ptr,
  input logic [WIDTH-1:0] rnd,
  input logic             vld
);

  assert_ptr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_ptr <= AW'(DEPTH - 1));

  assert_ptr_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && wr_ptr == AW'(DEPTH - 1)) |=> (wr_ptr == '0));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> ($stable(rnd) && $stable(wr_ptr)));

  assert_vld_high_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_i |=> vld);

  assert_vld_low_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> !vld);

endmodule

bind prng_bytestream prng_bytestream_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_core_n),
  .en_i   (en_i),
  .wr_ptr (wr_ptr),
  .rnd    (rnd_o),
  .vld    (rnd_vld_o)
);

// File: tb/prng_bytestream_bench.sv
module prng_bytestream_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic en;
  logic [7:0] d100, d63, d7;
  logic v100, v63, v7;

  prng_bytestream u_prng_bytestream (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rnd_o(d100), .rnd_vld_o(v100));

  prng_bytestream #(.LEN_SEL(prng_pkg::LEN_63)) u_len63 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rnd_o(d63), .rnd_vld_o(v63));

  prng_bytestream #(.LEN_SEL(prng_pkg::LEN_CUSTOM), .CUSTOM_DEPTH(7), .CUSTOM_TAP(6)) u_len7 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rnd_o(d7), .rnd_vld_o(v7));

  int checks = 0;
  int errors = 0;
  int sc;
  logic [7:0] m100 [100];
  logic [7:0] m63  [63];
  logic [7:0] m7   [7];
  logic [7:0] e100, e63, e7;
  logic       ev;
  logic [7:0] trace7 [300];
  int         n7;
  bit         trace_on;

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 100; i++) m100[i] = 8'h00;
    for (int i = 0; i < 63; i++)  m63[i]  = 8'h00;
    for (int i = 0; i < 7; i++)   m7[i]   = 8'h00;
    e100 = 8'h00; e63 = 8'h00; e7 = 8'h00; ev = 1'b0;
  endtask

  // plain shift-vector model: index 0 is the newest byte
  task automatic model_step();
    e100 = ~(m100[99] ^ m100[62]);
    for (int i = 99; i > 0; i--) m100[i] = m100[i-1];
    m100[0] = e100;
    e63 = ~(m63[62] ^ m63[61]);
    for (int i = 62; i > 0; i--) m63[i] = m63[i-1];
    m63[0] = e63;
    e7 = ~(m7[6] ^ m7[5]);
    for (int i = 6; i > 0; i--) m7[i] = m7[i-1];
    m7[0] = e7;
    if (trace_on && n7 < 300) begin
      trace7[n7] = e7;
      n7++;
    end
  endtask

  task automatic tick();
    bit act;
    bit en_s;
    act  = rst_n && (sc >= 2);
    en_s = en;
    @(posedge clk);
    #1;
    if (rst_n && sc < 2) sc++;
    if (act) begin
      ev = en_s;
      if (en_s) model_step();
    end else begin
      ev = 1'b0;
    end
    check8(en_s ? "R2/R3/R4" : "R5", d100, e100);
    check8("R7", d63, e63);
    check8("R8", d7, e7);
    check8("R6", {7'd0, v100}, {7'd0, ev});
    check8("R6", {7'd0, v63},  {7'd0, ev});
    check8("R6", {7'd0, v7},   {7'd0, ev});
  endtask

  task automatic release_and_start();
    rst_n = 1'b1;
    en    = 1'b1;
    tick();
    check8("R10", d100, 8'h00);
    tick();
    check8("R10", d100, 8'h00);
    tick();
    check8("R9", d100, 8'hFF);
    check8("R9", d63, 8'hFF);
    check8("R9", d7, 8'hFF);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      en = ($urandom % 4) != 0;
      tick();
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    en = 1'b0;
    sc = 0;
    n7 = 0;
    trace_on = 1'b1;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    check8("R1", d100, 8'h00);
    check8("R1", d63, 8'h00);
    check8("R1", {7'd0, v100}, 8'h00);
    check8("R1", {7'd0, v7}, 8'h00);

    release_and_start();
    // directed: several idle cycles, then resume
    en = 1'b0;
    repeat (3) tick();
    en = 1'b1;
    repeat (120) tick();
    random_run(1500);

    // period of the 7-stage register (R8)
    begin
      bit early_zero = 1'b0;
      bit all_zero;
      for (int k = 0; k < 127; k++)
        check8("R8 period", trace7[k+127], trace7[k]);
      for (int s = 7; s <= 127; s++) begin
        all_zero = 1'b1;
        for (int j = s - 7; j < s; j++) if (trace7[j] != 8'h00) all_zero = 1'b0;
        if (s < 127 && all_zero) early_zero = 1'b1;
        if (s == 127) check8("R8 return", {7'd0, all_zero}, 8'h01);
      end
      check8("R8 early", {7'd0, early_zero}, 8'h00);
    end
    trace_on = 1'b0;

    // asynchronous reset in mid-run (R10, R1)
    en = 1'b1;
    rst_n = 1'b0;
    #1;
    check8("R10", d100, 8'h00);
    check8("R10", d7, 8'h00);
    check8("R10", {7'd0, v63}, 8'h00);
    sc = 0;
    model_clear();
    repeat (2) tick();
    release_and_start();
    random_run(500);

    summary();
    $finish;
  end

endmodule